// File: doc/BRIEF.md
# Strided Memory Address Generator

This block produces the memory address stream for one global bus that carries data between memory and a pipelined reconfigurable fabric. Software-visible setup is done once through a configuration load strobe, which captures an access kind code, a starting index, a stride magnitude, a stride sign and an iteration period. From then on the block presents a request (read or write, depending on the access kind) together with the current address, and each time the memory side reports a completed transfer the address moves by the stride, up or down.

Each instance is tied at elaboration time to one bus through a parameter. Two of the access kinds carry per-stage state out of the fabric and back into it, and they are only honoured on the bus reserved for them: state saving on bus 0 and state reloading on bus 1. A combined save-and-reload kind on bus 1 alternates a read and a write at each address. A period counter marks the end of each pass over the configured number of steps with a one-cycle pulse.

Top module: `stride_agen`

## Requirements
- R1: After reset the address is 0, neither request is asserted and iter_done is low.
- R2: One cycle after cfg_load is sampled high, addr equals cfg_init and the period counter is cleared; cfg_load takes priority over a transfer-done in the same cycle.
- R3: When a step is taken, cfg_dir = 1 adds the stride to the address and cfg_dir = 0 subtracts it, modulo 2^ADDR_W; without a transfer-done the address holds.
- R4: Kind code 1 (last-stage output) holds wr_req high; kind code 2 (first-stage input) holds rd_req high; each transfer-done takes one step.
- R5: Kind codes 0, 3, 4, 8 and 9 to 15 are unused: no request is raised, transfer-done is ignored, the address holds and iter_done stays low.
- R6: Kind code 5 (state save) raises wr_req only when BUS_ID = 0 and kind code 7 (state reload) raises rd_req only when BUS_ID = 1; on any other bus each behaves as an unused code.
- R7: Kind code 6 on BUS_ID = 1 first raises rd_req; a transfer-done switches to wr_req at the same address, and the next transfer-done takes the step and returns to rd_req. On other buses code 6 is unused.
- R8: Steps are counted; the step that brings the count to cfg_period wraps it to zero and iter_done is high for the following cycle only. A period of 0 behaves like 1.
- R9: rd_req and wr_req are never high together.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous reset, active low |
| cfg_load | input | 1 | Capture the configuration fields this cycle |
| cfg_type | input | TYPE_W | Access kind code |
| cfg_init | input | ADDR_W | Starting index |
| cfg_stride | input | ADDR_W | Stride magnitude |
| cfg_dir | input | 1 | Stride sign: 1 up, 0 down |
| cfg_period | input | PER_W | Steps per iteration |
| xfer_done | input | 1 | Current transfer completed |
| addr | output | ADDR_W | Current memory address |
| rd_req | output | 1 | Memory read requested |
| wr_req | output | 1 | Memory write requested |
| iter_done | output | 1 | One-cycle pulse at the end of a period |

## Verification
The checker watches on every cycle that the two requests never overlap, that a load lands the starting index one cycle later, that the address is frozen whenever no transfer is reported or no request is raised, and that every iteration pulse follows a transfer-done that was not overridden by a load. The actual stride arithmetic, its wrap at the address width, the pulse count for a given period, the bus binding of the state kinds and the read-then-write order of the combined kind need chosen configurations and are shown only by the bench's scenarios.

// File: rtl/stride_agen_pkg.sv
package stride_agen_pkg;

    typedef enum logic [1:0] {
        MODE_IDLE = 2'd0,
        MODE_RD   = 2'd1,
        MODE_WR   = 2'd2,
        MODE_SWAP = 2'd3
    } agen_mode_e;

    localparam logic [3:0] KIND_OUT     = 4'd1;
    localparam logic [3:0] KIND_IN      = 4'd2;
    localparam logic [3:0] KIND_SAVE    = 4'd5;
    localparam logic [3:0] KIND_SWAP    = 4'd6;
    localparam logic [3:0] KIND_RELOAD  = 4'd7;

    localparam int SAVE_BUS   = 0;
    localparam int RELOAD_BUS = 1;

endpackage

// File: rtl/agen_decode.sv
module agen_decode
    import stride_agen_pkg::*;
#(
    parameter int TYPE_W = 4,
    parameter int BUS_ID = 0
) (
    input  logic [TYPE_W-1:0] code,
    output agen_mode_e        mode
);
    localparam bit ON_SAVE_BUS   = (BUS_ID == SAVE_BUS);
    localparam bit ON_RELOAD_BUS = (BUS_ID == RELOAD_BUS);

    logic [3:0] code4;

    always_comb begin
        code4 = 4'(code);
        if (TYPE_W > 4 && (code >> 4) != '0) begin
            code4 = 4'd0;
        end
    end

    always_comb begin
        case (code4)
            KIND_OUT:    mode = MODE_WR;
            KIND_IN:     mode = MODE_RD;
            KIND_SAVE:   mode = ON_SAVE_BUS   ? MODE_WR   : MODE_IDLE;
            KIND_SWAP:   mode = ON_RELOAD_BUS ? MODE_SWAP : MODE_IDLE;
            KIND_RELOAD: mode = ON_RELOAD_BUS ? MODE_RD   : MODE_IDLE;
            default:     mode = MODE_IDLE;
        endcase
    end
endmodule

// File: rtl/agen_step.sv
module agen_step #(
    parameter int ADDR_W = 8
) (
    input  logic [ADDR_W-1:0] cur,
    input  logic [ADDR_W-1:0] stride,
    input  logic              up,
    output logic [ADDR_W-1:0] nxt
);
    always_comb begin
        if (up) begin
            nxt = cur + stride;
        end else begin
            nxt = cur - stride;
        end
    end
endmodule

// File: rtl/stride_agen.sv
module stride_agen
    import stride_agen_pkg::*;
#(
    parameter int ADDR_W = 8,
    parameter int PER_W  = 4,
    parameter int TYPE_W = 4,
    parameter int BUS_ID = 0
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              cfg_load,
    input  logic [TYPE_W-1:0] cfg_type,
    input  logic [ADDR_W-1:0] cfg_init,
    input  logic [ADDR_W-1:0] cfg_stride,
    input  logic              cfg_dir,
    input  logic [PER_W-1:0]  cfg_period,
    input  logic              xfer_done,
    output logic [ADDR_W-1:0] addr,
    output logic              rd_req,
    output logic              wr_req,
    output logic              iter_done
);
    localparam int CNT_W = PER_W + 1;

    typedef struct packed {
        logic [ADDR_W-1:0] addr;
        logic [ADDR_W-1:0] stride;
        logic              up;
        logic [PER_W-1:0]  period;
        agen_mode_e        mode;
        logic              wr_phase;
        logic [PER_W-1:0]  cnt;
        logic              iter;
    } agen_state_t;

    agen_state_t s_d, s_q;
    agen_mode_e  load_mode;
    logic [ADDR_W-1:0] step_addr;
    logic [CNT_W-1:0]  cnt_inc;
    logic              take_step;

    agen_decode #(.TYPE_W(TYPE_W), .BUS_ID(BUS_ID)) u_decode (
        .code (cfg_type),
        .mode (load_mode)
    );

    agen_step #(.ADDR_W(ADDR_W)) u_step (
        .cur    (s_q.addr),
        .stride (s_q.stride),
        .up     (s_q.up),
        .nxt    (step_addr)
    );

    always_comb begin
        s_d       = s_q;
        s_d.iter  = 1'b0;
        cnt_inc   = CNT_W'(s_q.cnt) + CNT_W'(1);
        take_step = 1'b0;
        if (cfg_load) begin
            s_d.addr     = cfg_init;
            s_d.stride   = cfg_stride;
            s_d.up       = cfg_dir;
            s_d.period   = cfg_period;
            s_d.mode     = load_mode;
            s_d.wr_phase = 1'b0;
            s_d.cnt      = '0;
        end else if (xfer_done) begin
            case (s_q.mode)
                MODE_IDLE: take_step = 1'b0;
                MODE_SWAP: begin
                    if (!s_q.wr_phase) begin
                        s_d.wr_phase = 1'b1;
                    end else begin
                        take_step = 1'b1;
                    end
                end
                default:   take_step = 1'b1;
            endcase
            if (take_step) begin
                s_d.addr     = step_addr;
                s_d.wr_phase = 1'b0;
                if (cnt_inc >= CNT_W'(s_q.period)) begin
                    s_d.cnt  = '0;
                    s_d.iter = 1'b1;
                end else begin
                    s_d.cnt  = cnt_inc[PER_W-1:0];
                end
            end
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            s_q <= '{addr: '0, stride: '0, up: 1'b0, period: '0,
                     mode: MODE_IDLE, wr_phase: 1'b0, cnt: '0, iter: 1'b0};
        end else begin
            s_q <= s_d;
        end
    end

    assign addr      = s_q.addr;
    assign iter_done = s_q.iter;
    assign rd_req    = (s_q.mode == MODE_RD) || (s_q.mode == MODE_SWAP && !s_q.wr_phase);
    assign wr_req    = (s_q.mode == MODE_WR) || (s_q.mode == MODE_SWAP &&  s_q.wr_phase);

endmodule

// File: rtl/stride_agen_chk.sv
module stride_agen_chk #(
    parameter int ADDR_W = 8
) (
    input logic              clk,
    input logic              rst_n,
    input logic              cfg_load,
    input logic [ADDR_W-1:0] cfg_init,
    input logic              xfer_done,
    input logic [ADDR_W-1:0] addr,
    input logic              rd_req,
    input logic              wr_req,
    input logic              iter_done
);
    AST_REQ_EXCLUSIVE: assert property (@(posedge clk) disable iff (!rst_n)
        !(rd_req && wr_req)); // R9

    AST_LOAD_INDEX: assert property (@(posedge clk) disable iff (!rst_n)
        cfg_load |=> (addr == $past(cfg_init))); // R2

    AST_HOLD_NO_XFER: assert property (@(posedge clk) disable iff (!rst_n)
        (!cfg_load && !xfer_done) |=> $stable(addr)); // R3

    AST_IDLE_FROZEN: assert property (@(posedge clk) disable iff (!rst_n)
        (!cfg_load && !rd_req && !wr_req) |=> ($stable(addr) && !iter_done)); // R5

    AST_ITER_CAUSE: assert property (@(posedge clk) disable iff (!rst_n)
        iter_done |-> ($past(xfer_done) && !$past(cfg_load))); // R8
endmodule

bind stride_agen stride_agen_chk #(.ADDR_W(ADDR_W)) u_chk (.*);

// File: tb/stride_agen_test.sv
module stride_agen_test;
    localparam int AW = 8;
    localparam int PW = 4;
    localparam int TW = 4;

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic          cfg_load = 1'b0;
    logic [TW-1:0] cfg_type = '0;
    logic [AW-1:0] cfg_init = '0;
    logic [AW-1:0] cfg_stride = '0;
    logic          cfg_dir = 1'b0;
    logic [PW-1:0] cfg_period = '0;
    logic          xfer_done = 1'b0;
    logic [AW-1:0] addr, addr1;
    logic          rd_req, wr_req, iter_done;
    logic          rd_req1, wr_req1, iter_done1;

    int checks = 0;
    int errors = 0;
    int cycles = 0;
    int pulses;

    always #10 clk = ~clk;

    stride_agen #(.ADDR_W(AW), .PER_W(PW), .TYPE_W(TW), .BUS_ID(0)) uut (
        .clk, .rst_n, .cfg_load, .cfg_type, .cfg_init, .cfg_stride, .cfg_dir,
        .cfg_period, .xfer_done, .addr, .rd_req, .wr_req, .iter_done);

    stride_agen #(.ADDR_W(AW), .PER_W(PW), .TYPE_W(TW), .BUS_ID(1)) uut1 (
        .clk, .rst_n, .cfg_load, .cfg_type, .cfg_init, .cfg_stride, .cfg_dir,
        .cfg_period, .xfer_done, .addr(addr1), .rd_req(rd_req1), .wr_req(wr_req1),
        .iter_done(iter_done1));

    typedef struct packed {
        logic [3:0] kind;
        logic [7:0] init;
        logic [7:0] stride;
        logic       dir;
        logic [3:0] period;
        logic [3:0] steps;
        logic [7:0] exp_addr;
        logic [3:0] exp_iter;
        logic       exp_rd;
        logic       exp_wr;
    } vec_t;

    localparam int NV = 10;
    localparam vec_t VECS [NV] = '{
        '{4'd1, 8'd10,  8'd3, 1'b1, 4'd4, 4'd5, 8'd25,  4'd1, 1'b0, 1'b1},
        '{4'd2, 8'd100, 8'd7, 1'b0, 4'd2, 4'd4, 8'd72,  4'd2, 1'b1, 1'b0},
        '{4'd2, 8'd250, 8'd4, 1'b1, 4'd3, 4'd3, 8'd6,   4'd1, 1'b1, 1'b0},
        '{4'd1, 8'd5,   8'd6, 1'b0, 4'd0, 4'd2, 8'd249, 4'd2, 1'b0, 1'b1},
        '{4'd5, 8'd20,  8'd1, 1'b1, 4'd5, 4'd4, 8'd24,  4'd0, 1'b0, 1'b1},
        '{4'd3, 8'd40,  8'd2, 1'b1, 4'd1, 4'd3, 8'd40,  4'd0, 1'b0, 1'b0},
        '{4'd8, 8'd60,  8'd5, 1'b1, 4'd1, 4'd2, 8'd60,  4'd0, 1'b0, 1'b0},
        '{4'd7, 8'd30,  8'd1, 1'b1, 4'd1, 4'd2, 8'd30,  4'd0, 1'b0, 1'b0},
        '{4'd6, 8'd33,  8'd1, 1'b1, 4'd1, 4'd2, 8'd33,  4'd0, 1'b0, 1'b0},
        '{4'd0, 8'd7,   8'd9, 1'b0, 4'd1, 4'd3, 8'd7,   4'd0, 1'b0, 1'b0}
    };

    function automatic string vec_tag(int i);
        case (i)
            0: return "R4 R3 R8";
            1: return "R4 R3 R8";
            2: return "R3 wrap up R8";
            3: return "R3 wrap down R8 period0";
            4: return "R6 save on bus0";
            5: return "R5 code3";
            6: return "R5 code8";
            7: return "R6 reload off bus1";
            8: return "R7 swap off bus1";
            default: return "R5 code0";
        endcase
    endfunction

    task automatic check(input string tag, input int act, input int exp);
        checks++;
        if (act != exp) begin
            errors++;
            $display("FAIL %s: actual %0d expected %0d", tag, act, exp);
        end
    endtask

    task automatic load(input logic [3:0] k, input logic [7:0] ini,
                        input logic [7:0] st, input logic d, input logic [3:0] per);
        cfg_load = 1'b1; cfg_type = k; cfg_init = ini;
        cfg_stride = st; cfg_dir = d; cfg_period = per;
        @(negedge clk);
        cfg_load = 1'b0;
    endtask

    task automatic xfer();
        xfer_done = 1'b1;
        @(negedge clk);
        xfer_done = 1'b0;
        if (iter_done) pulses++;
    endtask

    always @(posedge clk) begin
        cycles++;
        if (cycles > 20000) begin
            errors++;
            $display("FAIL watchdog: actual %0d expected %0d", cycles, 20000);
            $display("Simulation finished: %0d checks, %0d errors", checks, errors);
            $finish;
        end
    end

    initial begin
        repeat (3) @(negedge clk);
        check("R1 addr", int'(addr), 0);
        check("R1 rd_req", int'(rd_req), 0);
        check("R1 wr_req", int'(wr_req), 0);
        check("R1 iter_done", int'(iter_done), 0);
        rst_n = 1'b1;
        @(negedge clk);

        for (int i = 0; i < NV; i++) begin
            load(VECS[i].kind, VECS[i].init, VECS[i].stride, VECS[i].dir, VECS[i].period);
            pulses = 0;
            for (int s = 0; s < int'(VECS[i].steps); s++) xfer();
            @(negedge clk);
            if (iter_done) pulses++;
            check($sformatf("vec %0d %s addr", i, vec_tag(i)), int'(addr), int'(VECS[i].exp_addr));
            check($sformatf("vec %0d %s iter", i, vec_tag(i)), pulses, int'(VECS[i].exp_iter));
            check($sformatf("vec %0d %s rd", i, vec_tag(i)), int'(rd_req), int'(VECS[i].exp_rd));
            check($sformatf("vec %0d %s wr", i, vec_tag(i)), int'(wr_req), int'(VECS[i].exp_wr));
            check($sformatf("vec %0d R9 overlap", i), int'(rd_req && wr_req), 0);
        end

        // R2: load wins over a simultaneous transfer-done
        load(4'd1, 8'd70, 8'd2, 1'b1, 4'd3);
        xfer_done = 1'b1;
        load(4'd1, 8'd77, 8'd2, 1'b1, 4'd3);
        xfer_done = 1'b0;
        check("R2 load priority addr", int'(addr), 77);

        // R2: load clears the period counter
        pulses = 0;
        xfer(); xfer();
        load(4'd1, 8'd0, 8'd1, 1'b1, 4'd3);
        xfer(); xfer();
        check("R2 counter cleared no pulse", pulses, 0);
        xfer();
        check("R2 pulse after full period", pulses, 1);
        @(negedge clk);
        check("R8 pulse lasts one cycle", int'(iter_done), 0);
        check("R3 hold without xfer", int'(addr), 3);

        // R7: swap on bus 1
        load(4'd6, 8'd50, 8'd10, 1'b1, 4'd2);
        check("R7 first phase rd", int'(rd_req1), 1);
        check("R7 first phase wr", int'(wr_req1), 0);
        check("R7 first phase addr", int'(addr1), 50);
        xfer();
        check("R7 second phase wr", int'(wr_req1), 1);
        check("R7 second phase rd", int'(rd_req1), 0);
        check("R7 second phase addr", int'(addr1), 50);
        xfer();
        check("R7 stepped addr", int'(addr1), 60);
        check("R7 back to rd", int'(rd_req1), 1);
        check("R7 no early pulse", int'(iter_done1), 0);

        // R6: bus binding of state kinds
        load(4'd7, 8'd90, 8'd1, 1'b0, 4'd1);
        check("R6 reload bus1 rd", int'(rd_req1), 1);
        check("R6 reload bus0 idle", int'(rd_req | wr_req), 0);
        xfer();
        check("R6 reload bus1 steps down", int'(addr1), 89);
        load(4'd5, 8'd91, 8'd1, 1'b1, 4'd1);
        check("R6 save bus1 idle", int'(rd_req1 | wr_req1), 0);
        check("R6 save bus0 wr", int'(wr_req), 1);
        xfer();
        check("R6 save bus1 addr held", int'(addr1), 91);
        check("R6 save bus0 steps", int'(addr), 92);

        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end
endmodule